// File: doc/BRIEF.md
# MII Transmit Phase Shifter

The block sits between a transmit nibble source and the transmit pins of an Ethernet PHY that runs from the same 25 MHz reference. The two devices share that reference, so their clocks have a fixed phase relation. This lets the block drop both a transmit FIFO and any use of the PHY's own transmit clock. It runs on a fast clock phase-locked to the reference, with `PHASES` fast cycles per reference period (four by default, so one step is 10 ns). It takes in one enable bit and one nibble for each reference period. It then replays them a programmable number of quarter periods later, so the PHY's setup and hold window can be hit by setting a register value.

The reference edge is the fast clock edge at which the phase-zero strobe is sampled high. At that edge the block samples the nibble and the shift code. Its output register then updates exactly `shift` fast edges later. Between strobes a free-running phase counter keeps the cadence going. A strobe at any edge forces phase zero again.

The enable works as the valid of a push-only stream. There is no ready, because an MII nibble stream cannot be stalled. The source must present a nibble at every reference edge, and the block applies no back-pressure. The shift code and the strobe are plain control pins.

Top module: `mii_tx_phase_shift`

## Requirements
- R1: With shift code s (2 bits, 0 to 3), the outputs take the nibble sampled at a reference edge exactly s fast-clock edges after that edge. With s = 0 they take it at that same edge.
- R2: `tx_en_o` and all `tx_d_o` bits update at the same edge, as one word.
- R3: `tx_en_i` and `tx_d_i` are sampled only at reference edges, and at edges the counter marks as phase zero. Values presented at any other edge never reach the outputs.
- R4: With a steady shift code and a strobe every four edges, each nibble appears at the outputs exactly once. It holds for exactly four fast cycles, and no nibble is lost or repeated.
- R5: The shift code is sampled only at phase-zero edges. A change made in the middle of a period does not move the update of the nibble already in flight.
- R6: While `rst_n` is low the outputs are 0. After release they stay 0 until the first strobe, and the first nibble appears at the programmed phase after it.
- R7: Between strobes the phase counter wraps from 3 to 0 by itself and samples a new nibble at the wrap. A strobe that comes early restarts the period at phase zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, PHASES cycles per reference period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb_i | input | 1 | High at the fast edge that coincides with the reference rising edge |
| shift_i | input | 2 | Delay code in quarter periods (SW bits in general) |
| tx_en_i | input | 1 | Transmit enable from the nibble source (stream valid) |
| tx_d_i | input | 4 | Transmit nibble from the nibble source |
| tx_en_o | output | 1 | Phase-shifted transmit enable to the PHY |
| tx_d_o | output | 4 | Phase-shifted transmit nibble to the PHY |

## Verification
The bench builds the block with its defaults, PHASES = 4 and DATA_W = 4, so the 2-bit shift code spans every quarter-period position of the reference period. It also makes the 3-to-0 and 0-to-2 code changes possible, where one period is shortened or stretched. At these values every phase of every shift code can be checked cycle by cycle against a reference edge. This covers the zero-delay path through the launch register, the free-running wrap and an early resynchronising strobe.

// File: rtl/mts_pkg.sv
package mts_pkg;

  // Default geometry: four fast cycles per reference period, one nibble.
  localparam int unsigned MTS_PHASES_DEF = 4;
  localparam int unsigned MTS_DATA_W_DEF = 4;

  // Width of a phase index; never less than one bit.
  function automatic int unsigned mts_ph_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mts_phase_ctr.sv
module mts_phase_ctr #(
  parameter int unsigned PHASES = mts_pkg::MTS_PHASES_DEF,
  localparam int unsigned PW = mts_pkg::mts_ph_bits(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_stb_i,
  output logic [PW-1:0] edge_ph_o,
  output logic          live_o
);

  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  logic [PW-1:0] ph_q;
  logic          seen_q;

  // Phase that the coming edge stands for; a strobe forces zero.
  always_comb begin
    if (ref_stb_i)
      edge_ph_o = '0;
    else if (ph_q == LAST_PH)
      edge_ph_o = '0;
    else
      edge_ph_o = ph_q + PW'(1);
  end

  assign live_o = seen_q | ref_stb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= LAST_PH;
      seen_q <= 1'b0;
    end else begin
      ph_q <= edge_ph_o;
      if (ref_stb_i)
        seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mts_hold.sv
module mts_hold #(
  parameter int unsigned PHASES = mts_pkg::MTS_PHASES_DEF,
  parameter int unsigned DATA_W = mts_pkg::MTS_DATA_W_DEF,
  localparam int unsigned SW = mts_pkg::mts_ph_bits(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [SW-1:0]     shift_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [SW-1:0]     shift_q_o,
  output logic              en_q_o,
  output logic [DATA_W-1:0] d_q_o
);

  // One nibble and its delay code, taken once per reference period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q_o <= '0;
      en_q_o    <= 1'b0;
      d_q_o     <= '0;
    end else if (take_i) begin
      shift_q_o <= shift_i;
      en_q_o    <= en_i;
      d_q_o     <= d_i;
    end
  end

endmodule

// File: rtl/mts_launch.sv
module mts_launch #(
  parameter int unsigned PHASES = mts_pkg::MTS_PHASES_DEF,
  parameter int unsigned DATA_W = mts_pkg::MTS_DATA_W_DEF,
  localparam int unsigned SW = mts_pkg::mts_ph_bits(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_i,
  input  logic [SW-1:0]     edge_ph_i,
  input  logic [SW-1:0]     shift_i,
  input  logic [SW-1:0]     shift_q_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              hold_en_i,
  input  logic [DATA_W-1:0] hold_d_i,
  output logic              en_o,
  output logic [DATA_W-1:0] d_o
);

  logic              at_zero;
  logic [SW-1:0]     sh_eff;
  logic              fire;
  logic              src_en;
  logic [DATA_W-1:0] src_d;

  assign at_zero = (edge_ph_i == '0);
  // At phase zero the fresh code rules; later in the period the held one.
  assign sh_eff  = at_zero ? shift_i : shift_q_i;
  assign fire    = live_i && (edge_ph_i == sh_eff);

  generate
    if (PHASES > 1) begin : g_bypass
      // Zero delay bypasses the holding register so no cycle is added.
      assign src_en = at_zero ? en_i : hold_en_i;
      assign src_d  = at_zero ? d_i  : hold_d_i;
    end else begin : g_direct
      logic unused_hold;
      assign unused_hold = hold_en_i ^ (^hold_d_i);
      assign src_en = en_i;
      assign src_d  = d_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= 1'b0;
      d_o  <= '0;
    end else if (fire) begin
      en_o <= src_en;
      d_o  <= src_d;
    end
  end

endmodule

// File: rtl/mii_tx_phase_shift.sv
module mii_tx_phase_shift #(
  parameter int unsigned PHASES = mts_pkg::MTS_PHASES_DEF,
  parameter int unsigned DATA_W = mts_pkg::MTS_DATA_W_DEF,
  localparam int unsigned SW = mts_pkg::mts_ph_bits(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_stb_i,
  input  logic [SW-1:0]     shift_i,
  input  logic              tx_en_i,
  input  logic [DATA_W-1:0] tx_d_i,
  output logic              tx_en_o,
  output logic [DATA_W-1:0] tx_d_o
);

  logic [SW-1:0]     edge_ph;
  logic              live;
  logic              take;
  logic [SW-1:0]     shift_q;
  logic              hold_en;
  logic [DATA_W-1:0] hold_d;

  mts_phase_ctr #(.PHASES(PHASES)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb_i (ref_stb_i),
    .edge_ph_o (edge_ph),
    .live_o    (live)
  );

  assign take = live && (edge_ph == '0);

  mts_hold #(.PHASES(PHASES), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .shift_i   (shift_i),
    .en_i      (tx_en_i),
    .d_i       (tx_d_i),
    .shift_q_o (shift_q),
    .en_q_o    (hold_en),
    .d_q_o     (hold_d)
  );

  mts_launch #(.PHASES(PHASES), .DATA_W(DATA_W)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (live),
    .edge_ph_i (edge_ph),
    .shift_i   (shift_i),
    .shift_q_i (shift_q),
    .en_i      (tx_en_i),
    .d_i       (tx_d_i),
    .hold_en_i (hold_en),
    .hold_d_i  (hold_d),
    .en_o      (tx_en_o),
    .d_o       (tx_d_o)
  );

endmodule

// File: rtl/mts_chk.sv
module mts_chk #(
  parameter int unsigned PHASES = mts_pkg::MTS_PHASES_DEF,
  parameter int unsigned DATA_W = mts_pkg::MTS_DATA_W_DEF,
  localparam int unsigned SW = mts_pkg::mts_ph_bits(PHASES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_stb_i,
  input logic [SW-1:0]     shift_i,
  input logic              tx_en_i,
  input logic [DATA_W-1:0] tx_d_i,
  input logic              tx_en_o,
  input logic [DATA_W-1:0] tx_d_o
);

  logic strobed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      strobed_q <= 1'b0;
    else if (ref_stb_i)
      strobed_q <= 1'b1;
  end

  AST_QUIET_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobed_q |-> (!tx_en_o && tx_d_o == '0)); // R6

  AST_ZERO_SHIFT_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb_i && shift_i == '0) |=> ({tx_en_o, tx_d_o} == $past({tx_en_i, tx_d_i}))); // R1

  AST_NONZERO_SHIFT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb_i && shift_i != '0) |=> $stable({tx_en_o, tx_d_o})); // R5

  AST_ONE_UPDATE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed({tx_en_o, tx_d_o}) && !ref_stb_i) |=> $stable({tx_en_o, tx_d_o})); // R4

endmodule

bind mii_tx_phase_shift mts_chk #(.PHASES(PHASES), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_stb_i (ref_stb_i),
  .shift_i   (shift_i),
  .tx_en_i   (tx_en_i),
  .tx_d_i    (tx_d_i),
  .tx_en_o   (tx_en_o),
  .tx_d_o    (tx_d_o)
);

// File: tb/sim_mii_tx_phase_shift.sv
module sim_mii_tx_phase_shift;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_stb = 1'b0;
  logic [1:0] shift = 2'd0;
  logic       tx_en = 1'b1;
  logic [3:0] tx_d = 4'hF;
  logic       tx_en_o;
  logic [3:0] tx_d_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mii_tx_phase_shift u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb_i (ref_stb),
    .shift_i   (shift),
    .tx_en_i   (tx_en),
    .tx_d_i    (tx_d),
    .tx_en_o   (tx_en_o),
    .tx_d_o    (tx_d_o)
  );

  // Row: {shift code, data seed, enable per frame (bit k for frame k)}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 4'h3, 3'b101},
    {2'd1, 4'hA, 3'b111},
    {2'd2, 4'h6, 3'b011},
    {2'd3, 4'hF, 3'b110},
    {2'd3, 4'h0, 3'b111},
    {2'd0, 4'h9, 3'b010},
    {2'd2, 4'hC, 3'b111},
    {2'd1, 4'h5, 3'b001}
  };

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Called at a negedge: drive, let one rising edge pass, return at next negedge.
  task automatic step(input logic stb, input logic [1:0] sh, input logic en, input logic [3:0] d);
    ref_stb = stb;
    shift   = sh;
    tx_en   = en;
    tx_d    = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] exp_w;
    logic [1:0] act_sh;
    logic [1:0] sh_drv;

    // R6: outputs zero under reset with busy inputs
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 reset", {tx_en_o, tx_d_o}, 5'h00);
    end
    rst_n = 1'b1;
    // R6: no strobe yet, outputs stay zero whatever is presented
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 2'(i), 1'b1, 4'(i + 7));
      check("R6 pre-strobe", {tx_en_o, tx_d_o}, 5'h00);
    end

    // Table walk: every shift code, mid-period code changes, off-phase garbage
    exp_w  = 5'h00;
    act_sh = 2'd0;
    sh_drv = VEC[0][8:7];
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 3; k++) begin
        for (int p = 0; p < 4; p++) begin
          logic       n_en;
          logic [3:0] n_d;
          n_en = VEC[r][k];
          n_d  = VEC[r][6:3] + 4'(k * 5);
          if (k == 2 && p == 1 && r < 7)
            sh_drv = VEC[r+1][8:7];
          if (p == 0)
            step(1'b1, sh_drv, n_en, n_d);
          else
            step(1'b0, sh_drv, ~n_en, ~n_d);
          if (p == 0)
            act_sh = sh_drv;
          if (2'(p) == act_sh)
            exp_w = {n_en, n_d};
          check("R1 R2 R3 R4 R5 table", {tx_en_o, tx_d_o}, exp_w);
        end
      end
    end

    // R7: free-running wrap and early resynchronising strobe
    step(1'b1, 2'd2, 1'b1, 4'h5);
    step(1'b0, 2'd2, 1'b0, 4'h0);
    step(1'b0, 2'd2, 1'b0, 4'h1);
    check("R1 shift2 lands", {tx_en_o, tx_d_o}, 5'h15);
    step(1'b0, 2'd2, 1'b0, 4'h2);
    step(1'b0, 2'd2, 1'b1, 4'h9);
    check("R4 hold before wrap update", {tx_en_o, tx_d_o}, 5'h15);
    step(1'b0, 2'd2, 1'b0, 4'h3);
    step(1'b0, 2'd2, 1'b0, 4'h4);
    check("R7 wrap sample", {tx_en_o, tx_d_o}, 5'h19);
    step(1'b1, 2'd1, 1'b0, 4'hC);
    check("R7 early strobe no move", {tx_en_o, tx_d_o}, 5'h19);
    step(1'b0, 2'd1, 1'b1, 4'h6);
    check("R7 early strobe restart", {tx_en_o, tx_d_o}, 5'h0C);

    // R6: reset mid-stream, then first nibble at programmed phase 3
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 async clear", {tx_en_o, tx_d_o}, 5'h00);
    rst_n = 1'b1;
    step(1'b1, 2'd3, 1'b1, 4'hA);
    step(1'b0, 2'd3, 1'b0, 4'h1);
    step(1'b0, 2'd3, 1'b0, 4'h2);
    check("R6 before first phase", {tx_en_o, tx_d_o}, 5'h00);
    step(1'b0, 2'd3, 1'b0, 4'h3);
    check("R6 first nibble phase3", {tx_en_o, tx_d_o}, 5'h1A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule